// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time as packed BCD fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year that counts from 1970 (00 is 1970, 99 is 2069). A one-cycle enable arriving once per second moves the time forward by one second. Carries ripple through every field. The block knows how long each month is. February takes 29 days when the leap flag kept with the year is set. The hour field always counts through a 24-hour day.

Software sets the time through a small register port. Field writes go into a staging copy and do not touch the running time. Writing 1 to bit 15 of the trigger register then moves the whole staged copy into the running counter in one cycle, so the time never holds a half-written mix of fields. A read returns the running time one clock after the address is presented.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, day 01, month 01, year 00 with the leap flag clear, the trigger register reads 0 and control bit 0 reads 1.
- R2: Register offsets are seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5, year 6 (BCD in bits 7:0, leap flag in bit 15), trigger 7 (bit 15) and control 8 (bit 0). Read data is registered and shows the addressed register one cycle after the address is presented. Stored widths are seconds 7, minutes 7, hours 6, weekday 3, day 6, month 5 and year 8 bits. Wider write bits and unused offsets read as 0.
- R3: Writes to the field registers change only the staged copy. The running time does not change until a commit.
- R4: Writing bit 15 of the trigger register as 1 loads every staged field, including the leap flag, into the running time on the next clock. The trigger reads 0 once that commit is done.
- R5: A one-second tick in the same cycle as a commit is dropped, and the written values are kept unchanged.
- R6: On each tick the seconds go up by one in BCD (09 becomes 10). Seconds roll from 59 to 00 and carry into minutes, and minutes roll from 59 to 00 and carry into hours.
- R7: Hours roll from 23 to 00 and carry into the day and the weekday. The weekday wraps from 6 to 0.
- R8: The day rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in all other months except February.
- R9: In February the day rolls to 01 after 28 when the leap flag is clear and after 29 when it is set.
- R10: The month rolls from 12 to 01 and carries into the year. The year rolls from 99 to 00.
- R11: When the year advances, the leap flag is set exactly when 1970 plus the new year value is divisible by 4.
- R12: Without a tick or a commit the running time holds its value.
- R13: Control bit 0 can be written and read back. Hours count through 00 to 23 whatever its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| reg_addr_i | input | ADDR_W | Register offset for reads and writes |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data for the offset presented the cycle before |

## Verification
The range assertions assume that software only writes legal BCD values: seconds and minutes up to 59, hours up to 23, and a month from 01 to 12. Given legal fields, the counter can never leave those ranges. The stimulus loads only legal times. The one test of field masking uses the weekday field, which no range assertion covers. Trigger writes are always separated by idle cycles, and ticks are spaced apart, so each commit and each advance can be observed on its own.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

  localparam int REG_W    = 16;
  localparam int FLAG_BIT = 15;

  localparam int OFS_SEC  = 0;
  localparam int OFS_MIN  = 1;
  localparam int OFS_HOUR = 2;
  localparam int OFS_WDAY = 3;
  localparam int OFS_DAY  = 4;
  localparam int OFS_MON  = 5;
  localparam int OFS_YEAR = 6;
  localparam int OFS_TRIG = 7;  // directly follows the year register
  localparam int OFS_CTRL = 8;

  typedef struct packed {
    logic       leap;
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] day;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_time_t;

  localparam cal_time_t CAL_RESET = '{leap: 1'b0, year: 8'h00, mon: 5'h01,
                                      day: 6'h01, wday: 3'd0, hour: 6'h00,
                                      min: 7'h00, sec: 7'h00};

  // Two-digit BCD increment, no wrap handling.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Last day of a BCD month.
  function automatic logic [5:0] month_last(input logic [4:0] m, input logic lp);
    case (m)
      5'h02:                      return lp ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // 1970 + y divisible by 4 <=> y mod 4 == 2; y mod 4 = (2*tens + ones) mod 4.
  function automatic logic year_is_leap(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return s[1:0] == 2'b10;
  endfunction

endpackage

// File: rtl/cal_regbank.sv
module cal_regbank
  import bcd_calendar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output cal_time_t         staged_o,
  output logic              commit_o,
  output logic              ctrl_24h_o
);

  cal_time_t stg_q;
  logic      commit_q;
  logic      ctrl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stg_q    <= CAL_RESET;
      commit_q <= 1'b0;
      ctrl_q   <= 1'b1;
    end else begin
      commit_q <= wr_i && (addr_i == ADDR_W'(OFS_TRIG)) && wdata_i[FLAG_BIT];
      if (wr_i) begin
        case (addr_i)
          ADDR_W'(OFS_SEC):  stg_q.sec  <= wdata_i[6:0];
          ADDR_W'(OFS_MIN):  stg_q.min  <= wdata_i[6:0];
          ADDR_W'(OFS_HOUR): stg_q.hour <= wdata_i[5:0];
          ADDR_W'(OFS_WDAY): stg_q.wday <= wdata_i[2:0];
          ADDR_W'(OFS_DAY):  stg_q.day  <= wdata_i[5:0];
          ADDR_W'(OFS_MON):  stg_q.mon  <= wdata_i[4:0];
          ADDR_W'(OFS_YEAR): begin
            stg_q.year <= wdata_i[7:0];
            stg_q.leap <= wdata_i[FLAG_BIT];
          end
          ADDR_W'(OFS_CTRL): ctrl_q <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assign staged_o   = stg_q;
  assign commit_o   = commit_q;
  assign ctrl_24h_o = ctrl_q;

endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import bcd_calendar_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      tick_i,
  input  logic      load_i,
  input  cal_time_t load_val_i,
  output cal_time_t now_o
);

  cal_time_t now_q;
  cal_time_t nxt;
  logic c_min, c_hour, c_day, c_mon, c_year;
  logic [7:0] s8, m8, h8, d8, mo8, y8;

  always_comb begin
    s8  = bcd_inc({1'b0, now_q.sec});
    m8  = bcd_inc({1'b0, now_q.min});
    h8  = bcd_inc({2'b0, now_q.hour});
    d8  = bcd_inc({2'b0, now_q.day});
    mo8 = bcd_inc({3'b0, now_q.mon});
    y8  = bcd_inc(now_q.year);

    c_min  = (now_q.sec == 7'h59);
    c_hour = c_min  && (now_q.min == 7'h59);
    c_day  = c_hour && (now_q.hour == 6'h23);
    c_mon  = c_day  && (now_q.day == month_last(now_q.mon, now_q.leap));
    c_year = c_mon  && (now_q.mon == 5'h12);

    nxt = now_q;
    nxt.sec = c_min ? 7'h00 : s8[6:0];
    if (c_min)  nxt.min  = c_hour ? 7'h00 : m8[6:0];
    if (c_hour) nxt.hour = c_day ? 6'h00 : h8[5:0];
    if (c_day) begin
      nxt.wday = (now_q.wday == 3'd6) ? 3'd0 : now_q.wday + 3'd1;
      nxt.day  = c_mon ? 6'h01 : d8[5:0];
    end
    if (c_mon) nxt.mon = c_year ? 5'h01 : mo8[4:0];
    if (c_year) begin
      nxt.year = (now_q.year == 8'h99) ? 8'h00 : y8;
      nxt.leap = year_is_leap(nxt.year);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       now_q <= CAL_RESET;
    else if (load_i) now_q <= load_val_i;
    else if (tick_i) now_q <= nxt;
  end

  assign now_o = now_q;

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_calendar_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o
);

  cal_time_t staged_q;
  cal_time_t live_q;
  logic      commit_q;
  logic      ctrl_24h;
  logic [REG_W-1:0] rdata_q;

  cal_regbank #(.ADDR_W(ADDR_W)) regs_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .staged_o   (staged_q),
    .commit_o   (commit_q),
    .ctrl_24h_o (ctrl_24h)
  );

  cal_counter cnt_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .load_i     (commit_q),
    .load_val_i (staged_q),
    .now_o      (live_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr_i)
        ADDR_W'(OFS_SEC):  rdata_q <= REG_W'(live_q.sec);
        ADDR_W'(OFS_MIN):  rdata_q <= REG_W'(live_q.min);
        ADDR_W'(OFS_HOUR): rdata_q <= REG_W'(live_q.hour);
        ADDR_W'(OFS_WDAY): rdata_q <= REG_W'(live_q.wday);
        ADDR_W'(OFS_DAY):  rdata_q <= REG_W'(live_q.day);
        ADDR_W'(OFS_MON):  rdata_q <= REG_W'(live_q.mon);
        ADDR_W'(OFS_YEAR): rdata_q <= {live_q.leap, 7'b0, live_q.year};
        ADDR_W'(OFS_TRIG): rdata_q <= {commit_q, 15'b0};
        ADDR_W'(OFS_CTRL): rdata_q <= REG_W'(ctrl_24h);
        default:           rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import bcd_calendar_pkg::*;
(
  input logic      clk_i,
  input logic      rst_i,
  input logic      tick_i,
  input logic      commit_q,
  input cal_time_t live_q,
  input cal_time_t staged_q
);

  // R4 and R5: a commit loads the staged copy, tick or not
  a_r4_commit_loads: assert property (@(posedge clk_i) disable iff (rst_i)
    commit_q |=> (live_q == $past(staged_q)));

  // R12: no tick and no commit keeps the time
  a_r12_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && !commit_q) |=> $stable(live_q));

  // R6: a tick below 59 seconds moves the seconds
  a_r6_sec_moves: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !commit_q && live_q.sec != 7'h59) |=> (live_q.sec != $past(live_q.sec)));

  // R6: seconds stay legal BCD
  a_r6_sec_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_q.sec <= 7'h59) && (live_q.sec[3:0] <= 4'd9));

  // R7: hours stay within a 24-hour day
  a_r7_hour_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_q.hour <= 6'h23) && (live_q.hour[3:0] <= 4'd9));

  // R10: month stays 01..12
  a_r10_month_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (live_q.mon >= 5'h01) && (live_q.mon <= 5'h12));

endmodule

bind bcd_calendar bcd_calendar_chk chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .tick_i   (tick_i),
  .commit_q (commit_q),
  .live_q   (live_q),
  .staged_q (staged_q)
);

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NVEC = 15;

  // each entry: start {s,m,h,w,d,mo,y,lp} then expected after one tick
  localparam logic [127:0] VEC [NVEC] = '{
    {64'h00000000_01010000, 64'h01000000_01010000},  // R6
    {64'h09341202_10051000, 64'h10341202_10051000},  // R6 digit carry
    {64'h59341202_10051000, 64'h00351202_10051000},  // R6 minute carry
    {64'h59591901_20061100, 64'h00002001_20061100},  // R6 hour carry
    {64'h59592306_15030500, 64'h00000000_16030500},  // R7 weekday wrap
    {64'h59592302_28020100, 64'h00000003_01030100},  // R9 non-leap Feb
    {64'h59592302_28020201, 64'h00000003_29020201},  // R9 leap Feb 28
    {64'h59592303_29020201, 64'h00000004_01030201},  // R9 leap Feb 29
    {64'h59592304_30042000, 64'h00000005_01052000},  // R8 April
    {64'h59592305_30112000, 64'h00000006_01122000},  // R8 November
    {64'h59592300_31012000, 64'h00000001_01022000},  // R8 January
    {64'h59592301_30082000, 64'h00000002_31082000},  // R8 August
    {64'h59592302_31120100, 64'h00000003_01010201},  // R10 R11 into leap year
    {64'h59592303_31129900, 64'h00000004_01010000},  // R10 year wrap
    {64'h59592304_31122900, 64'h00000005_01013001}   // R11 year 2000
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [15:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [15:0] d);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load_time(input logic [63:0] t);
    wreg(0, {8'h00, t[63:56]});
    wreg(1, {8'h00, t[55:48]});
    wreg(2, {8'h00, t[47:40]});
    wreg(3, {8'h00, t[39:32]});
    wreg(4, {8'h00, t[31:24]});
    wreg(5, {8'h00, t[23:16]});
    wreg(6, {t[0], 7'b0, t[15:8]});
    wreg(7, 16'h8000);
    @(negedge clk);
  endtask

  task automatic check_time(input string tag, input logic [63:0] t);
    logic [15:0] d;
    rreg(0, d); check({tag, " R6 sec"},  d, {8'h00, t[63:56]});
    rreg(1, d); check({tag, " R6 min"},  d, {8'h00, t[55:48]});
    rreg(2, d); check({tag, " R7 hour"}, d, {8'h00, t[47:40]});
    rreg(3, d); check({tag, " R7 wday"}, d, {8'h00, t[39:32]});
    rreg(4, d); check({tag, " R8/R9 day"}, d, {8'h00, t[31:24]});
    rreg(5, d); check({tag, " R10 mon"}, d, {8'h00, t[23:16]});
    rreg(6, d); check({tag, " R10/R11 year+leap"}, d, {t[0], 7'b0, t[15:8]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_time("R1 reset", 64'h00000000_01010000);
    rreg(7, d); check("R1 trigger", d, 16'h0000);
    rreg(8, d); check("R1 ctrl", d, 16'h0001);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      load_time(VEC[i][127:64]);
      check_time($sformatf("R4 load vec%0d", i), VEC[i][127:64]);
      do_tick();
      check_time($sformatf("vec%0d", i), VEC[i][63:0]);
    end

    // R3 staging does not touch live time
    load_time(64'h00000000_01010000);
    wreg(0, 16'h0045);
    rreg(0, d); check("R3 staged not live", d, 16'h0000);
    wreg(7, 16'h8000);
    @(negedge clk);
    rreg(0, d); check("R4 commit sec", d, 16'h0045);
    rreg(7, d); check("R4 trigger cleared", d, 16'h0000);

    // R2 masking and unused offset
    wreg(3, 16'hFFFF);
    wreg(0, 16'h8012);
    wreg(7, 16'h8000);
    @(negedge clk);
    rreg(3, d); check("R2 wday mask", d, 16'h0007);
    rreg(0, d); check("R2 sec mask", d, 16'h0012);
    rreg(9, d); check("R2 unused offset", d, 16'h0000);

    // R5 tick on the commit cycle is dropped
    wreg(0, 16'h0030);
    wreg(7, 16'h8000);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    rreg(0, d); check("R5 tick dropped", d, 16'h0030);

    // R12 hold without tick
    rreg(0, d);
    repeat (5) @(negedge clk);
    rreg(0, d2); check("R12 hold", d2, d);

    // R6 many ticks: 00:00:00 + 61 s
    load_time(64'h00000000_01010000);
    for (int k = 0; k < 61; k++) begin
      do_tick();
      @(negedge clk);
    end
    rreg(0, d); check("R6 multi sec", d, 16'h0001);
    rreg(1, d); check("R6 multi min", d, 16'h0001);

    // R13 control bit and 24-hour counting
    wreg(8, 16'h0000);
    rreg(8, d); check("R13 ctrl write", d, 16'h0000);
    load_time(64'h59591202_10051000);
    do_tick();
    rreg(2, d); check("R13 hour 13", d, 16'h0013);
    load_time(64'h59592302_10051000);
    do_tick();
    rreg(2, d); check("R13 hour wrap", d, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule